// File: doc/BRIEF.md
# Multi-Context Two-Level Page Table Walker

The walker turns a 40-bit virtual address into a physical page address. It does this for one of sixteen address-space contexts, reading 64-bit table entries through a simple memory read port. A context may be mapped either by one flat table of page entries or by a directory whose entries point to page blocks. The size of a page block is a configuration setting, and it moves the boundary between the directory index and the block index in the virtual address.

Context 0, the system context, has its own layout setting and its own block-size setting. Contexts 1 to 15 share a second pair of these settings. Every context has its own table base. The client presents a context number, a virtual address and an access type. The walker performs one walk at a time and answers with either a physical address and its page attributes, or a fault and its cause.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are both 0.
- R2: Context 0 takes `cfg_sys_two_lvl`/`cfg_sys_bs`. Contexts 1 to 15 take `cfg_usr_two_lvl`/`cfg_usr_bs`. Context c takes its table base page from `cfg_base[28*c +: 28]`, and the byte base is that page times 4096.
- R3: In single-level mode the walker makes exactly one read, at base + 8*VA[39:12], with all arithmetic taken modulo 2^40.
- R4: In two-level mode the first read is at base + 8*VA[39:21+bs]. If that entry is valid, the second read is at PDE[39:12]*4096 + 8*VA[20+bs:12].
- R5: Every block size bs from 0 to 7 selects a block of 512<<bs entries, and the indexing of R4 follows the selected size.
- R6: A directory entry with bit 0 clear ends the walk with `rsp_fault`=1 and `rsp_cause`=1 (not present). No second read is made.
- R7: A page entry with bit 0 clear gives `rsp_fault`=1 and `rsp_cause`=1.
- R8: For a valid page entry, a read (`req_write`=0) without bit 5 set, or a write without bit 6 set, gives `rsp_fault`=1 and `rsp_cause`=2 (permission). The not-present check takes priority over the permission check.
- R9: On success the walker gives `rsp_fault`=0 and `rsp_cause`=0. It returns `rsp_pa`={PTE[39:12],VA[11:0]}, `rsp_frag`=PTE[11:7], `rsp_snoop`=PTE[2] and `rsp_sys`=PTE[1]. On a fault, `rsp_pa`, `rsp_frag`, `rsp_sys` and `rsp_snoop` are all 0.
- R10: Only one walk is in flight at a time.
  - `req_ready` is 0 from the acceptance of a request until its response.
  - `mem_req_valid` stays high with a stable address until `mem_req_ready` accepts it.
  - `rsp_valid` is a single-cycle pulse that follows a memory response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_ctx | input | 4 | Context number |
| req_va | input | 40 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_sys_two_lvl | input | 1 | Context 0 uses two-level tables |
| cfg_sys_bs | input | 3 | Context 0 block size |
| cfg_usr_two_lvl | input | 1 | Contexts 1 to 15 use two-level tables |
| cfg_usr_bs | input | 3 | Contexts 1 to 15 block size |
| cfg_base | input | 448 | Per-context table base pages, 28 bits each |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 40 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 permission |
| rsp_pa | output | 40 | Physical address |
| rsp_frag | output | 5 | Fragment field |
| rsp_sys | output | 1 | Page in system memory |
| rsp_snoop | output | 1 | Snooped access |

## Verification
The bench sweeps every block size, with the directory index taken from the bits just above the block index. A walker with an off-by-one boundary would read the wrong directory or block entry, and the recorded read addresses would expose it. A system-context request and a user-context request are issued for the same address under different layouts. A walker that applied the shared settings to context 0 would make the wrong number of reads. Invalid directory entries must end the walk after one read, and an extra read shows a walker that ignores the valid bit. Entries that are both invalid and lacking permission show whether the fault causes are prioritised in the right order.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W = 40,
  parameter int CTX_N = 16,
  localparam int CTX_W = $clog2(CTX_N),
  localparam int PG_W = VA_W - 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CTX_W-1:0]   req_ctx,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_write,
  input  logic               cfg_sys_two_lvl,
  input  logic [2:0]         cfg_sys_bs,
  input  logic               cfg_usr_two_lvl,
  input  logic [2:0]         cfg_usr_bs,
  input  logic [CTX_N*PG_W-1:0] cfg_base,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [VA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [63:0]        mem_rsp_data,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [VA_W-1:0]    rsp_pa,
  output logic [4:0]         rsp_frag,
  output logic               rsp_sys,
  output logic               rsp_snoop
);

  typedef enum logic [2:0] {S_IDLE, S_PDE_REQ, S_PDE_WAIT, S_PTE_REQ, S_PTE_WAIT} st_t;
  st_t st;

  logic [VA_W-1:0] va_q, addr_q;
  logic            wr_q;
  logic [2:0]      bs_q;

  wire             is_sys   = (req_ctx == '0);
  wire             two_sel  = is_sys ? cfg_sys_two_lvl : cfg_usr_two_lvl;
  wire [2:0]       bs_sel   = is_sys ? cfg_sys_bs : cfg_usr_bs;
  wire [PG_W-1:0]  base_sel = cfg_base[req_ctx*PG_W +: PG_W];
  wire [VA_W-1:0]  base_b   = {base_sel, 12'h000};

  wire [VA_W-1:0]  flat_addr = base_b + VA_W'({req_va[VA_W-1:12], 3'b000});
  wire [VA_W-1:0]  pde_addr  = base_b + ((req_va >> (21 + int'(bs_sel))) << 3);

  wire [VA_W-1:0]  blk_mask  = (VA_W'(512) << bs_q) - VA_W'(1);
  wire [VA_W-1:0]  pte_addr  = {mem_rsp_data[VA_W-1:12], 12'h000}
                             + (((va_q >> 12) & blk_mask) << 3);

  wire             pte_noperm = wr_q ? !mem_rsp_data[6] : !mem_rsp_data[5];
  wire [1:0]       pte_cause  = !mem_rsp_data[0] ? 2'd1 : (pte_noperm ? 2'd2 : 2'd0);

  logic unused_bits;
  assign unused_bits = ^{mem_rsp_data[63:VA_W], mem_rsp_data[4:3]};

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_PDE_REQ) || (st == S_PTE_REQ);
  assign mem_req_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va_q      <= '0;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      bs_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'd0;
      rsp_pa    <= '0;
      rsp_frag  <= '0;
      rsp_sys   <= 1'b0;
      rsp_snoop <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          wr_q   <= req_write;
          bs_q   <= bs_sel;
          addr_q <= two_sel ? pde_addr : flat_addr;
          st     <= two_sel ? S_PDE_REQ : S_PTE_REQ;
        end
        S_PDE_REQ: if (mem_req_ready) st <= S_PDE_WAIT;
        S_PDE_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_cause <= 2'd1;
            rsp_pa    <= '0;
            rsp_frag  <= '0;
            rsp_sys   <= 1'b0;
            rsp_snoop <= 1'b0;
            st        <= S_IDLE;
          end else begin
            addr_q <= pte_addr;
            st     <= S_PTE_REQ;
          end
        end
        S_PTE_REQ: if (mem_req_ready) st <= S_PTE_WAIT;
        S_PTE_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_fault <= (pte_cause != 2'd0);
          rsp_cause <= pte_cause;
          if (pte_cause == 2'd0) begin
            rsp_pa    <= {mem_rsp_data[VA_W-1:12], va_q[11:0]};
            rsp_frag  <= mem_rsp_data[11:7];
            rsp_sys   <= mem_rsp_data[1];
            rsp_snoop <= mem_rsp_data[2];
          end else begin
            rsp_pa    <= '0;
            rsp_frag  <= '0;
            rsp_sys   <= 1'b0;
            rsp_snoop <= 1'b0;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [VA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause,
  input logic [VA_W-1:0] rsp_pa,
  input logic [4:0]      rsp_frag,
  input logic            rsp_sys,
  input logic            rsp_snoop
);

  // R10
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  rsp_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rsp_valid));

  // R9
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == '0 && rsp_frag == '0 && !rsp_sys && !rsp_snoop && rsp_cause != 2'd0);

  // R9
  ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == 2'd0);

  // R3
  aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W)) u_chk (.*);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [3:0]   req_ctx = '0;
  logic [39:0]  req_va = '0;
  logic         sys_two = 1'b0, usr_two = 1'b1;
  logic [2:0]   sys_bs = '0, usr_bs = '0;
  logic [447:0] cfg_base = '0;
  logic         mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [39:0]  mem_req_addr;
  logic [63:0]  mem_rsp_data = '0;
  logic         rsp_valid, rsp_fault, rsp_sys, rsp_snoop;
  logic [1:0]   rsp_cause;
  logic [39:0]  rsp_pa;
  logic [4:0]   rsp_frag;

  pt_walker u_pt_walker (
    .clk, .rst_n, .req_valid, .req_ready, .req_ctx, .req_va, .req_write,
    .cfg_sys_two_lvl(sys_two), .cfg_sys_bs(sys_bs),
    .cfg_usr_two_lvl(usr_two), .cfg_usr_bs(usr_bs), .cfg_base,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .rsp_valid, .rsp_fault, .rsp_cause, .rsp_pa, .rsp_frag, .rsp_sys, .rsp_snoop);

  logic [63:0] mem [logic [39:0]];
  logic [39:0] rd_log [256];
  int unsigned rd_n = 0;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
      rd_log[rd_n[7:0]] <= mem_req_addr;
      rd_n <= rd_n + 1;
    end
    mem_req_ready <= ($urandom % 4) != 0;
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [39:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic void addrs(input logic [3:0] ctx, input logic [39:0] va,
                                output logic two, output logic [39:0] first,
                                output logic [39:0] idx);
    logic [2:0] bs;
    logic [39:0] base;
    two  = (ctx == 0) ? sys_two : usr_two;
    bs   = (ctx == 0) ? sys_bs : usr_bs;
    base = {cfg_base[ctx*28 +: 28], 12'h0};
    idx  = (40'(va[39:12])) & ((40'd512 << bs) - 40'd1);
    if (two) first = base + ((va >> (21 + int'(bs))) * 8);
    else     first = base + 40'(va[39:12]) * 8;
  endfunction

  // expected result from R2..R9
  function automatic void model(input logic [3:0] ctx, input logic [39:0] va, input logic wr,
      output logic [1:0] c, output logic [39:0] pa, output logic [4:0] fr,
      output logic s, output logic sn, output int n, output logic [39:0] a0, output logic [39:0] a1);
    logic two;
    logic [39:0] idx;
    logic [63:0] p, e;
    addrs(ctx, va, two, a0, idx);
    c = 0; pa = 0; fr = 0; s = 0; sn = 0; a1 = 0; n = 1;
    if (!two) e = rd(a0);
    else begin
      p = rd(a0);
      if (!p[0]) begin c = 1; return; end
      a1 = {p[39:12], 12'h0} + idx * 8;
      n = 2;
      e = rd(a1);
    end
    if (!e[0]) c = 1;
    else if (wr ? !e[6] : !e[5]) c = 2;
    else begin pa = {e[39:12], va[11:0]}; fr = e[11:7]; s = e[1]; sn = e[2]; end
  endfunction

  task automatic plant(input logic [3:0] ctx, input logic [39:0] va, input logic pde_v,
                       input logic [27:0] ptb, input logic [63:0] pte);
    logic two;
    logic [39:0] first, idx;
    addrs(ctx, va, two, first, idx);
    if (!two) mem[first] = pte;
    else begin
      mem[first] = {24'h0, ptb, 11'h0, pde_v};
      mem[{ptb, 12'h0} + idx * 8] = pte;
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [27:0] pg, input logic [4:0] fr,
      input logic w, input logic r, input logic sn, input logic sy, input logic v);
    return 64'({pg, fr, w, r, 2'b00, sn, sy, v});
  endfunction

  task automatic walk(input logic [3:0] ctx, input logic [39:0] va, input logic wr, input string tag);
    logic [1:0] c; logic [39:0] pa, a0, a1; logic [4:0] fr; logic s, sn; int n;
    int unsigned start;
    int t = 0;
    model(ctx, va, wr, c, pa, fr, s, sn, n, a0, a1);
    @(negedge clk);
    start = rd_n;
    req_valid = 1'b1; req_ctx = ctx; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, " R10 busy"}, 64'(req_ready), 64'd0);
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    chk(rsp_valid, {tag, " R10 response"}, 64'(rsp_valid), 64'd1);
    chk(rsp_cause == c && rsp_fault == (c != 0), {tag, " R6 R7 R8 cause"}, 64'(rsp_cause), 64'(c));
    chk(rsp_pa == pa && rsp_frag == fr && rsp_sys == s && rsp_snoop == sn,
        {tag, " R9 result"}, {rsp_frag, rsp_sys, rsp_snoop, rsp_pa}, {fr, s, sn, pa});
    chk(rd_n - start == n, {tag, " R3 R4 read count"}, 64'(rd_n - start), 64'(n));
    chk(rd_log[start[7:0]] == a0, {tag, " R2 R4 first address"}, 64'(rd_log[start[7:0]]), 64'(a0));
    if (n == 2)
      chk(rd_log[8'(start + 1)] == a1, {tag, " R4 R5 second address"}, 64'(rd_log[8'(start + 1)]), 64'(a1));
    @(negedge clk);
    chk(!rsp_valid, {tag, " R10 pulse"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int c = 0; c < 16; c++) cfg_base[c*28 +: 28] = 28'h0100000 + 28'(c) * 28'h10000;
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset", {req_ready, rsp_valid, mem_req_valid}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !mem_req_valid && rd_n == 0, "R1 idle after reset", 64'(rd_n), 64'd0);

    // R2: same VA, sys single-level vs user two-level
    sys_two = 0; usr_two = 1; usr_bs = 2;
    plant(0, 40'h12_3456_7abc, 1, 28'h0, mk_pte(28'hAAAAA, 5'd3, 1, 1, 1, 1, 1));
    plant(5, 40'h12_3456_7abc, 1, 28'h0777777, mk_pte(28'hBBBBB, 5'd1, 0, 1, 0, 1, 1));
    walk(0, 40'h12_3456_7abc, 1'b1, "R2 sys ctx R3");
    walk(5, 40'h12_3456_7abc, 1'b0, "R2 user ctx R4");
    // R8 write to read-only page
    walk(5, 40'h12_3456_7abc, 1'b1, "R8 write no W");
    // R6 invalid PDE
    plant(7, 40'h55_0000_1000, 0, 28'h0666666, mk_pte(28'h1, 0, 1, 1, 0, 0, 1));
    walk(7, 40'h55_0000_1000, 1'b0, "R6 PDE invalid");
    // R7 invalid PTE, R8 priority (no perms too)
    plant(8, 40'h01_0000_2000, 1, 28'h0555555, mk_pte(28'h2, 0, 0, 0, 0, 0, 0));
    walk(8, 40'h01_0000_2000, 1'b1, "R7 PTE invalid priority R8");
    // R8 read without R bit
    plant(9, 40'h02_0000_3000, 1, 28'h0444444, mk_pte(28'h3, 0, 1, 0, 0, 0, 1));
    walk(9, 40'h02_0000_3000, 1'b0, "R8 read no R");
    walk(9, 40'h02_0000_3000, 1'b1, "R8 write with W R9");
    // R5 every block size, top-of-index VA
    for (int b = 0; b < 8; b++) begin
      usr_bs = 3'(b);
      plant(3, 40'hFF_FFFF_FFFF, 1, 28'h0333000 + 28'(b), mk_pte(28'hC0000 + 28'(b), 5'(b), 1, 1, 1, 0, 1));
      walk(3, 40'hFF_FFFF_FFFF, 1'b0, "R5 block size");
    end
    // constrained random over both layout choices
    for (int i = 0; i < 300; i++) begin
      logic [3:0] ctx; logic [39:0] va; logic wr;
      if (i % 100 == 0) begin
        sys_two = 1'($urandom); usr_two = 1'($urandom);
        sys_bs = 3'($urandom); usr_bs = 3'($urandom);
      end
      ctx = 4'($urandom);
      va  = {8'($urandom), 32'($urandom)};
      wr  = 1'($urandom);
      if ($urandom % 8 != 0)
        plant(ctx, va, ($urandom % 10) != 0, 28'($urandom),
              mk_pte(28'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), ($urandom % 10) != 0));
      walk(ctx, va, wr, "R9 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule